// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible register file of a simple LCD panel controller. A 32-bit register port reaches six word registers at byte offsets 0x00 to 0x14: control, three timing words, status and a subpanel word. From those writes the block keeps the panel geometry, the pixel-load mode, the panel-type bits and a two-bit interrupt mask. It hands all of these to a separate frame engine as decoded fields.

The block also owns three sticky status flags: frame done, palette done and sync error. The frame engine sets them with one-cycle event pulses. A control write that changes the enable bit clears or sets them. A single level interrupt output is formed from the flags and the mask.

Reads are combinational in the cycle the read strobe is high. Some bits of the control and timing reads are constant ones, ORed over the live fields.

Top module: `lcdc_regs`

## Requirements
- R1: After reset the reads return: control 0xFE000C34, timing0 0x000003FF, timing1 0x000003FF, timing2 0xFC000000, status 0, subpanel 0. The interrupt is low and the frame slot is not armed.
- R2: A control write captures the fields below. A control read returns all of them ORed with 0xFE000C34.
  - load mode from bits 21:20
  - panel-type bit from bit 7 (read back at both bit 23 and bit 7)
  - interrupt mask from bits 4:3
  - mono bit from bit 1
  - enable from bit 0
  - the bits under mask 0x01CFF300, kept as written
- R3: A timing0 write (offset 0x04) sets the panel width to bits 9:0 plus one (range 1 to 1024) and keeps bits 31:10. Its read returns the kept bits in place, the width minus one in bits 9:0, and bits 3:0 forced to one.
- R4: A timing1 write (offset 0x08) sets the panel height to bits 9:0 plus one and keeps bits 31:10. Its read returns the same layout with no bits forced. A timing2 read (offset 0x0C) returns the written word with bits 31:26 forced to one.
- R5: A subpanel write (offset 0x14) is stored ANDed with 0xA1FFFFFF, and the stored word is presented to the frame engine.
- R6: The status read (offset 0x10) shows palette done at bit 6, sync error at bit 2 and frame done at bit 0, with every other bit zero. A write to the status offset changes nothing.
- R7: The interrupt is high exactly when one of these holds, and it follows any change of flags or mask in the same cycle:
  - frame done is set and mask bit 0 is set
  - palette done is set and mask bit 1 is set
  - sync error is set, whatever the mask
- R8: A control write that turns enable from one to zero clears sync error and disarms the frame slot. It sets frame done unless the newly written load mode is 1.
- R9: A control write that turns enable from zero to one while the frame slot is disarmed clears frame done and palette done and arms the slot. A control write that leaves enable unchanged runs no sequencing.
- R10: An access to any offset outside the six registers, or to an offset that is not word aligned, raises the bad-access output in that cycle. Such a read returns zero, and such a write changes no register.
- R11: While enabled, an engine event pulse sets its flag. While disabled, event pulses are ignored. When a control write that runs sequencing and an event fall in the same cycle, the sequencing decides the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle rdEn is high, else zero |
| badAccess | output | 1 | Access to an unmapped or misaligned offset |
| evFrameDone | input | 1 | Engine pulse: frame finished |
| evPaletteDone | input | 1 | Engine pulse: palette loaded |
| evSyncError | input | 1 | Engine pulse: frame sync failure |
| irq | output | 1 | Level interrupt |
| dispEnable | output | 1 | Controller enable |
| loadMode | output | 2 | Pixel-load mode |
| tftPanel | output | 1 | Active-matrix panel type |
| monoPanel | output | 1 | Monochrome panel |
| panelWidth | output | DIM_BITS+1 | Panel width in pixels |
| panelHeight | output | DIM_BITS+1 | Panel height in lines |
| subpanelCfg | output | 32 | Masked subpanel word |
| frameArmed | output | 1 | Frame slot armed (valid frame index 0) |

## Verification
Some rules are checked on every cycle:
- a raised sync error always drives the interrupt
- with all flags clear the interrupt stays low
- a falling enable edge clears sync error and disarms the slot
- a rising edge from the disarmed state clears both done flags
- unmapped reads return zero
- a status write leaves the flags alone
- the stored width tracks the written field plus one

Only the directed scenarios show the rest. These are the exact read-back images with their constant bits, the load-mode exception on disable, the per-mask-bit interrupt gating, event pulses ignored while disabled, and the untouched register contents after a stray write.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
  localparam logic [DATA_W-1:0] CTRL_READ_ONES = 32'hFE00_0C34;
  localparam logic [DATA_W-1:0] TIM0_READ_ONES = 32'h0000_000F;
  localparam logic [DATA_W-1:0] TIM2_READ_ONES = 32'hFC00_0000;
  localparam logic [DATA_W-1:0] SUB_KEEP_MASK  = 32'hA1FF_FFFF;

  // word index of each register (byte offset / 4)
  localparam int IDX_CTRL = 0;
  localparam int IDX_TIM0 = 1;
  localparam int IDX_TIM1 = 2;
  localparam int IDX_TIM2 = 3;
  localparam int IDX_STAT = 4;
  localparam int IDX_SUB  = 5;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_STAT, SEL_SUB, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrTim0;
    logic    wrTim1;
    logic    wrTim2;
    logic    wrSub;
    logic    rdHit;
    regSel_e rdSel;
    logic    bad;
  } regStrobe_t;

  typedef struct packed {
    logic paletteDone;
    logic syncErr;
    logic frameDone;
  } statFlags_t;

endpackage

// File: rtl/lcdc_ctrl.sv
module lcdc_ctrl
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe
);

  localparam int NUM_REGS = 6;

  logic    aligned;
  logic    mapped;
  regSel_e sel;

  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel    = SEL_NONE;
    mapped = 1'b0;
    if (aligned && (addr[ADDR_W-1:2] < (ADDR_W-2)'(NUM_REGS))) begin
      mapped = 1'b1;
      case (int'(addr[ADDR_W-1:2]))
        IDX_CTRL: sel = SEL_CTRL;
        IDX_TIM0: sel = SEL_TIM0;
        IDX_TIM1: sel = SEL_TIM1;
        IDX_TIM2: sel = SEL_TIM2;
        IDX_STAT: sel = SEL_STAT;
        IDX_SUB:  sel = SEL_SUB;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = sel;
    strobe.rdHit  = rdEn && mapped;
    strobe.wrCtrl = wrEn && (sel == SEL_CTRL);
    strobe.wrTim0 = wrEn && (sel == SEL_TIM0);
    strobe.wrTim1 = wrEn && (sel == SEL_TIM1);
    strobe.wrTim2 = wrEn && (sel == SEL_TIM2);
    strobe.wrSub  = wrEn && (sel == SEL_SUB);
    strobe.bad    = (wrEn || rdEn) && !mapped;
  end

endmodule

// File: rtl/lcdc_datapath.sv
module lcdc_datapath
  import lcdc_pkg::*;
#(
  parameter int DIM_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                evFrameDone,
  input  logic                evPaletteDone,
  input  logic                evSyncError,
  output logic [DATA_W-1:0]   rdData,
  output statFlags_t          flags,
  output logic                irq,
  output logic                dispEnable,
  output logic [1:0]          loadMode,
  output logic                tftPanel,
  output logic                monoPanel,
  output logic [DIM_BITS:0]   panelWidth,
  output logic [DIM_BITS:0]   panelHeight,
  output logic [DATA_W-1:0]   subpanelCfg,
  output logic                frameArmed
);

  localparam int DIM_W = DIM_BITS + 1;
  localparam int HI_W  = DATA_W - DIM_BITS;

  logic [1:0]          intMask;
  logic [DATA_W-1:0]   ctrlKeep;
  logic [HI_W-1:0]     tim0Hi;
  logic [HI_W-1:0]     tim1Hi;
  logic [DATA_W-1:0]   tim2Word;
  logic                newEnable;
  logic [1:0]          newMode;
  logic                enRise;
  logic                enFall;
  logic [DIM_BITS-1:0] widthM1;
  logic [DIM_BITS-1:0] heightM1;
  logic [DATA_W-1:0]   muxData;

  assign newEnable = wrData[0];
  assign newMode   = wrData[21:20];
  assign enRise    = strobe.wrCtrl && newEnable && !dispEnable;
  assign enFall    = strobe.wrCtrl && !newEnable && dispEnable;

  // configuration fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispEnable  <= 1'b0;
      loadMode    <= '0;
      tftPanel    <= 1'b0;
      monoPanel   <= 1'b0;
      intMask     <= '0;
      ctrlKeep    <= '0;
      tim0Hi      <= '0;
      tim1Hi      <= '0;
      tim2Word    <= '0;
      panelWidth  <= '0;
      panelHeight <= '0;
      subpanelCfg <= '0;
    end else begin
      if (strobe.wrCtrl) begin
        dispEnable <= newEnable;
        loadMode   <= newMode;
        tftPanel   <= wrData[7];
        monoPanel  <= wrData[1];
        intMask    <= wrData[4:3];
        ctrlKeep   <= wrData & CTRL_KEEP_MASK;
      end
      if (strobe.wrTim0) begin
        tim0Hi     <= wrData[DATA_W-1:DIM_BITS];
        panelWidth <= DIM_W'(wrData[DIM_BITS-1:0]) + 1'b1;
      end
      if (strobe.wrTim1) begin
        tim1Hi      <= wrData[DATA_W-1:DIM_BITS];
        panelHeight <= DIM_W'(wrData[DIM_BITS-1:0]) + 1'b1;
      end
      if (strobe.wrTim2) tim2Word    <= wrData;
      if (strobe.wrSub)  subpanelCfg <= wrData & SUB_KEEP_MASK;
    end
  end

  // status flags and frame slot; sequencing below overrides events
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags      <= '0;
      frameArmed <= 1'b0;
    end else begin
      if (dispEnable) begin
        if (evFrameDone)   flags.frameDone   <= 1'b1;
        if (evPaletteDone) flags.paletteDone <= 1'b1;
        if (evSyncError)   flags.syncErr     <= 1'b1;
      end
      if (enFall) begin
        flags.syncErr <= 1'b0;
        if (newMode != 2'd1) flags.frameDone <= 1'b1;
        frameArmed    <= 1'b0;
      end else if (enRise && !frameArmed) begin
        flags.frameDone   <= 1'b0;
        flags.paletteDone <= 1'b0;
        frameArmed        <= 1'b1;
      end
    end
  end

  assign irq = (flags.frameDone && intMask[0]) ||
               (flags.paletteDone && intMask[1]) ||
               flags.syncErr;

  assign widthM1  = DIM_BITS'(panelWidth - 1'b1);
  assign heightM1 = DIM_BITS'(panelHeight - 1'b1);

  always_comb begin
    case (strobe.rdSel)
      SEL_CTRL: muxData = CTRL_READ_ONES | ctrlKeep |
                          (DATA_W'(tftPanel) << 23) | (DATA_W'(loadMode) << 20) |
                          (DATA_W'(tftPanel) << 7)  | (DATA_W'(intMask) << 3) |
                          (DATA_W'(monoPanel) << 1) | DATA_W'(dispEnable);
      SEL_TIM0: muxData = {tim0Hi, widthM1} | TIM0_READ_ONES;
      SEL_TIM1: muxData = {tim1Hi, heightM1};
      SEL_TIM2: muxData = tim2Word | TIM2_READ_ONES;
      SEL_STAT: muxData = (DATA_W'(flags.paletteDone) << 6) |
                          (DATA_W'(flags.syncErr) << 2) |
                          DATA_W'(flags.frameDone);
      SEL_SUB:  muxData = subpanelCfg;
      default:  muxData = '0;
    endcase
  end

  assign rdData = strobe.rdHit ? muxData : '0;

endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DIM_BITS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              badAccess,
  input  logic              evFrameDone,
  input  logic              evPaletteDone,
  input  logic              evSyncError,
  output logic              irq,
  output logic              dispEnable,
  output logic [1:0]        loadMode,
  output logic              tftPanel,
  output logic              monoPanel,
  output logic [DIM_BITS:0] panelWidth,
  output logic [DIM_BITS:0] panelHeight,
  output logic [31:0]       subpanelCfg,
  output logic              frameArmed
);

  regStrobe_t strobe;
  statFlags_t flags;
  logic       fdFlag;
  logic       pdFlag;
  logic       seFlag;

  lcdc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  lcdc_datapath #(.DIM_BITS(DIM_BITS)) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (wrData),
    .evFrameDone   (evFrameDone),
    .evPaletteDone (evPaletteDone),
    .evSyncError   (evSyncError),
    .rdData        (rdData),
    .flags         (flags),
    .irq           (irq),
    .dispEnable    (dispEnable),
    .loadMode      (loadMode),
    .tftPanel      (tftPanel),
    .monoPanel     (monoPanel),
    .panelWidth    (panelWidth),
    .panelHeight   (panelHeight),
    .subpanelCfg   (subpanelCfg),
    .frameArmed    (frameArmed)
  );

  assign badAccess = strobe.bad;
  assign fdFlag    = flags.frameDone;
  assign pdFlag    = flags.paletteDone;
  assign seFlag    = flags.syncErr;

endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
  parameter int ADDR_W   = 8,
  parameter int DIM_BITS = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              badAccess,
  input logic              evFrameDone,
  input logic              evPaletteDone,
  input logic              evSyncError,
  input logic              irq,
  input logic              dispEnable,
  input logic              frameArmed,
  input logic [DIM_BITS:0] panelWidth,
  input logic              fdFlag,
  input logic              pdFlag,
  input logic              seFlag
);

  logic ctrlWr;
  logic statWr;
  logic anyEv;

  assign ctrlWr = wrEn && (addr == ADDR_W'(8'h00));
  assign statWr = wrEn && (addr == ADDR_W'(8'h10));
  assign anyEv  = evFrameDone || evPaletteDone || evSyncError;

  AST_SYNC_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    seFlag |-> irq); // R7

  AST_IDLE_IRQ_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!fdFlag && !pdFlag && !seFlag) |-> !irq); // R7

  AST_DISABLE_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && dispEnable && !wrData[0]) |=> (!seFlag && !frameArmed)); // R8

  AST_ENABLE_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !dispEnable && wrData[0] && !frameArmed)
      |=> (frameArmed && !fdFlag && !pdFlag)); // R9

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && badAccess) |-> (rdData == 32'h0)); // R10

  AST_STATUS_WR_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !anyEv) |=> ($stable(fdFlag) && $stable(pdFlag) && $stable(seFlag))); // R6

  AST_WIDTH_PLUS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_W'(8'h04)))
      |=> (panelWidth == (DIM_BITS+1)'($past(wrData[DIM_BITS-1:0])) + 1'b1)); // R3

endmodule

bind lcdc_regs lcdc_regs_chk #(.ADDR_W(ADDR_W), .DIM_BITS(DIM_BITS)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .wrEn          (wrEn),
  .rdEn          (rdEn),
  .addr          (addr),
  .wrData        (wrData),
  .rdData        (rdData),
  .badAccess     (badAccess),
  .evFrameDone   (evFrameDone),
  .evPaletteDone (evPaletteDone),
  .evSyncError   (evSyncError),
  .irq           (irq),
  .dispEnable    (dispEnable),
  .frameArmed    (frameArmed),
  .panelWidth    (panelWidth),
  .fdFlag        (fdFlag),
  .pdFlag        (pdFlag),
  .seFlag        (seFlag)
);

// File: tb/lcdc_regs_test.sv
`timescale 1ns/1ps
module lcdc_regs_test;

  localparam int ADDR_W   = 8;
  localparam int DIM_BITS = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic              badAccess;
  logic              evFrameDone = 1'b0;
  logic              evPaletteDone = 1'b0;
  logic              evSyncError = 1'b0;
  logic              irq;
  logic              dispEnable;
  logic [1:0]        loadMode;
  logic              tftPanel;
  logic              monoPanel;
  logic [DIM_BITS:0] panelWidth;
  logic [DIM_BITS:0] panelHeight;
  logic [31:0]       subpanelCfg;
  logic              frameArmed;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lcdc_regs #(.ADDR_W(ADDR_W), .DIM_BITS(DIM_BITS)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .badAccess(badAccess),
    .evFrameDone(evFrameDone), .evPaletteDone(evPaletteDone),
    .evSyncError(evSyncError), .irq(irq), .dispEnable(dispEnable),
    .loadMode(loadMode), .tftPanel(tftPanel), .monoPanel(monoPanel),
    .panelWidth(panelWidth), .panelHeight(panelHeight),
    .subpanelCfg(subpanelCfg), .frameArmed(frameArmed)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] off, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; addr = off; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [7:0] off, output logic [31:0] data, output logic bad);
    @(negedge clk);
    rdEn = 1'b1; addr = off;
    #1;
    data = rdData; bad = badAccess;
    rdEn = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [7:0] off, input logic [31:0] exp);
    logic [31:0] d;
    logic        b;
    regRead(off, d, b);
    check(tag, d, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    evFrameDone   = (which == 0);
    evPaletteDone = (which == 1);
    evSyncError   = (which == 2);
    @(negedge clk);
    evFrameDone = 1'b0; evPaletteDone = 1'b0; evSyncError = 1'b0;
  endtask

  task automatic tResetState();
    check("R1 irq", 32'(irq), 0);
    check("R1 armed", 32'(frameArmed), 0);
    expectReg("R1 ctrl", 8'h00, 32'hFE00_0C34);
    expectReg("R1 timing0", 8'h04, 32'h0000_03FF);
    expectReg("R1 timing1", 8'h08, 32'h0000_03FF);
    expectReg("R1 timing2", 8'h0C, 32'hFC00_0000);
    expectReg("R1 status", 8'h10, 32'h0);
    expectReg("R1 subpanel", 8'h14, 32'h0);
  endtask

  task automatic tControl();
    regWrite(8'h00, 32'hFFFF_FFFE);  // enable stays 0
    expectReg("R2 ctrl all", 8'h00, 32'hFFFF_FFBE);
    check("R2 mode port", 32'(loadMode), 3);
    check("R2 mono port", 32'(monoPanel), 1);
    regWrite(8'h00, 32'h0010_0088);
    expectReg("R2 ctrl sparse", 8'h00, 32'hFE90_0CBC);
    check("R2 tft port", 32'(tftPanel), 1);
    check("R2 enable port", 32'(dispEnable), 0);
    regWrite(8'h00, 32'h0);
  endtask

  task automatic tTiming();
    regWrite(8'h04, 32'hABCD_E123);
    expectReg("R3 timing0 read", 8'h04, 32'hABCD_E12F);
    check("R3 width", 32'(panelWidth), 32'h124);
    regWrite(8'h04, 32'h0000_03FF);
    check("R3 width max", 32'(panelWidth), 32'h400);
    expectReg("R3 timing0 max read", 8'h04, 32'h0000_03FF);
    regWrite(8'h08, 32'h1234_5000);
    check("R4 height min", 32'(panelHeight), 1);
    expectReg("R4 timing1 read", 8'h08, 32'h1234_5000);
    regWrite(8'h0C, 32'h0000_0055);
    expectReg("R4 timing2 read", 8'h0C, 32'hFC00_0055);
  endtask

  task automatic tSubpanel();
    regWrite(8'h14, 32'hFFFF_FFFF);
    expectReg("R5 subpanel read", 8'h14, 32'hA1FF_FFFF);
    check("R5 subpanel port", subpanelCfg, 32'hA1FF_FFFF);
  endtask

  task automatic tFlagsAndIrq();
    regWrite(8'h00, 32'h0000_0001);  // enable, mode 0, mask 0
    check("R9 armed", 32'(frameArmed), 1);
    expectReg("R9 status cleared", 8'h10, 32'h0);
    pulse(0);
    expectReg("R11 frame event", 8'h10, 32'h1);
    check("R7 masked frame", 32'(irq), 0);
    regWrite(8'h00, 32'h0000_0009);  // mask bit 0
    check("R7 frame mask0", 32'(irq), 1);
    pulse(1);
    expectReg("R11 palette event", 8'h10, 32'h41);
    regWrite(8'h00, 32'h0000_0011);  // mask bit 1 only
    check("R7 palette mask1", 32'(irq), 1);
    regWrite(8'h00, 32'h0000_0001);
    check("R7 no mask", 32'(irq), 0);
    pulse(2);
    check("R7 sync unmasked", 32'(irq), 1);
    expectReg("R6 status layout", 8'h10, 32'h45);
    regWrite(8'h10, 32'h0);
    expectReg("R6 status write ignored", 8'h10, 32'h45);
    regWrite(8'h00, 32'h0);  // disable, mode 0
    expectReg("R8 disable flags", 8'h10, 32'h41);
    check("R8 disarmed", 32'(frameArmed), 0);
    check("R8 irq after", 32'(irq), 0);
    pulse(2);
    expectReg("R11 event ignored disabled", 8'h10, 32'h41);
    regWrite(8'h00, 32'h0000_0001);
    expectReg("R9 re-enable clears", 8'h10, 32'h0);
    regWrite(8'h00, 32'h0010_0001);  // enable unchanged, mode 1
    check("R9 still armed", 32'(frameArmed), 1);
    regWrite(8'h00, 32'h0010_0000);  // disable with mode 1
    expectReg("R8 mode1 exception", 8'h10, 32'h0);
  endtask

  task automatic tBadAccess();
    logic [31:0] d;
    logic        b;
    regRead(8'h18, d, b);
    check("R10 bad read data", d, 0);
    check("R10 bad read flag", 32'(b), 1);
    regRead(8'h02, d, b);
    check("R10 misaligned flag", 32'(b), 1);
    regRead(8'h14, d, b);
    check("R10 good no flag", 32'(b), 0);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h16; wrData = 32'h0;
    #1;
    check("R10 bad write flag", 32'(badAccess), 1);
    @(negedge clk);
    wrEn = 1'b0;
    expectReg("R10 subpanel untouched", 8'h14, 32'hA1FF_FFFF);
    expectReg("R10 timing2 untouched", 8'h0C, 32'hFC00_0055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tResetState();
    tControl();
    tTiming();
    tSubpanel();
    tFlagsAndIrq();
    tBadAccess();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule